// File: doc/BRIEF.md
# Conditional memory-operation issue arbiter

At the issue stage a conditional load or store must not go ahead until two facts about it are known: whether its predicate holds, and whether the address it uses passed the protection lookup. This arbiter takes both results in the same cycle, together with a readiness flag from the memory unit, and settles them into one verdict per cycle. The verdict is one of four: issue to memory, stall and retry, raise a trap, or retire as a no-op. A trap carries a cause code, and a tag travels alongside each verdict so that the pipeline can match it to its instruction.

The predicate ranks above the address check. An operation whose predicate turns out false is retired as a no-op. It never reaches memory and never traps, even when its address would have faulted. Because operations are only held, dropped or started at this single point, a trapped or no-op operation leaves no side effect behind, and nothing ever has to be completed partway.

The request is first caught in an input register, which the `REG_INPUTS` option can remove. The verdict is then formed combinationally and held in an output register with a valid strobe. The result is due `1 + REG_INPUTS` cycles after the request is presented, and a new request may be presented every cycle.

Top module: `cond_mem_issue_arb`

## Requirements
- R1: While reset is asserted, and until the first result is due, `dec_valid` is 0, `dec_kind` is NOP (2'b00) and `dec_cause` is 0.
- R2: A cycle with `op_valid` = 0 produces, at its result slot, `dec_valid` = 0 with `dec_kind` NOP (2'b00) and `dec_cause` 0.
- R3: A request with `cond_known` = 0 yields STALL (2'b10), whatever the pointer flags and `unit_ready` are.
- R4: A request with `cond_known` = 1 and `cond_pass` = 0 yields NOP (2'b00) with `dec_valid` = 1 and `dec_cause` = 0, even when `ptr_bad` = 1 or `unit_ready` = 0.
- R5: A request whose condition is known and passing but with `ptr_known` = 0 yields STALL (2'b10).
- R6: A request whose condition is known and passing, with `ptr_known` = 1 and `ptr_bad` = 1, yields TRAP (2'b11) with `dec_cause` equal to `PTR_FAULT_CODE` (default 1), whatever `unit_ready` is.
- R7: A request whose condition is known and passing and whose pointer is known and good, but with `unit_ready` = 0, yields STALL (2'b10).
- R8: ISSUE (2'b01) is produced only when the condition is known and passing, the pointer is known and good, and `unit_ready` = 1. In that case it is always produced.
- R9: Each result appears exactly `1 + REG_INPUTS` cycles (2 by default) after its request is presented. Results follow one per cycle with no gap, and `dec_tag` equals that request's `op_tag`.
- R10: `dec_cause` is 0 whenever `dec_kind` is not TRAP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A conditional memory operation is presented this cycle |
| op_tag | input | TAG_W | Identifier of the presented operation |
| cond_known | input | 1 | The predicate result is available |
| cond_pass | input | 1 | The predicate holds (meaningful when cond_known = 1) |
| ptr_known | input | 1 | The address check result is available |
| ptr_bad | input | 1 | The address check failed (meaningful when ptr_known = 1) |
| unit_ready | input | 1 | The memory unit can accept an operation |
| dec_valid | output | 1 | A verdict is present |
| dec_kind | output | 2 | Verdict: 00 NOP, 01 ISSUE, 10 STALL, 11 TRAP |
| dec_cause | output | CAUSE_W | Trap cause, 0 unless TRAP |
| dec_tag | output | TAG_W | Tag of the operation this verdict belongs to |

## Verification
Every verdict, cause and tag is due two clock edges after its request, one for the input register and one for the output register. The bench drives a new request on each falling edge and compares the outputs at each later falling edge with the request given two falling edges before. It keeps a short history of past requests so that this offset is exact. All 64 combinations of the six request flags are streamed back to back in two different orders, so each verdict is also checked when it follows an unlike neighbour. The reset state is compared before the first result can be due.

// File: rtl/cmia_pkg.sv
`timescale 1ns/1ps
package cmia_pkg;

   typedef enum logic [1:0] {
      DEC_NOP   = 2'b00,
      DEC_ISSUE = 2'b01,
      DEC_STALL = 2'b10,
      DEC_TRAP  = 2'b11
   } dec_kind_e;

   typedef struct packed {
      logic op_valid;
      logic cond_known;
      logic cond_pass;
      logic ptr_known;
      logic ptr_bad;
      logic unit_ready;
   } op_req_t;

endpackage

// File: rtl/cmia_capture.sv
`timescale 1ns/1ps
module cmia_capture
   import cmia_pkg::*;
#(
   parameter int TAG_W      = 4,
   parameter int REG_INPUTS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_req_t          req_d,
   input  logic [TAG_W-1:0] tag_d,
   output op_req_t          req_q,
   output logic [TAG_W-1:0] tag_q
);

   generate
      if (REG_INPUTS != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= '0;
               tag_q <= '0;
            end else begin
               req_q <= req_d;
               tag_q <= tag_d;
            end
         end
      end else begin : g_pass
         assign req_q = req_d;
         assign tag_q = tag_d;
      end
   endgenerate

endmodule

// File: rtl/cmia_decide.sv
`timescale 1ns/1ps
module cmia_decide
   import cmia_pkg::*;
#(
   parameter int CAUSE_W        = 3,
   parameter int PTR_FAULT_CODE = 1
) (
   input  op_req_t            req,
   output logic               verdict_valid,
   output dec_kind_e          verdict,
   output logic [CAUSE_W-1:0] cause
);

   localparam logic [CAUSE_W-1:0] FAULT_CAUSE = CAUSE_W'(PTR_FAULT_CODE);

   always_comb begin
      verdict_valid = req.op_valid;
      verdict       = DEC_NOP;
      cause         = '0;
      if (!req.op_valid) begin
         verdict = DEC_NOP;
      end else if (!req.cond_known) begin
         verdict = DEC_STALL;
      end else if (!req.cond_pass) begin
         verdict = DEC_NOP;
      end else if (!req.ptr_known) begin
         verdict = DEC_STALL;
      end else if (req.ptr_bad) begin
         verdict = DEC_TRAP;
         cause   = FAULT_CAUSE;
      end else if (!req.unit_ready) begin
         verdict = DEC_STALL;
      end else begin
         verdict = DEC_ISSUE;
      end
   end

endmodule

// File: rtl/cmia_hold.sv
`timescale 1ns/1ps
module cmia_hold
   import cmia_pkg::*;
#(
   parameter int TAG_W   = 4,
   parameter int CAUSE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_d,
   input  dec_kind_e          kind_d,
   input  logic [CAUSE_W-1:0] cause_d,
   input  logic [TAG_W-1:0]   tag_d,
   output logic               valid_q,
   output dec_kind_e          kind_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [TAG_W-1:0]   tag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         kind_q  <= DEC_NOP;
         cause_q <= '0;
         tag_q   <= '0;
      end else begin
         valid_q <= valid_d;
         kind_q  <= kind_d;
         cause_q <= cause_d;
         tag_q   <= tag_d;
      end
   end

endmodule

// File: rtl/cond_mem_issue_arb.sv
`timescale 1ns/1ps
module cond_mem_issue_arb
   import cmia_pkg::*;
#(
   parameter int TAG_W          = 4,
   parameter int CAUSE_W        = 3,
   parameter int PTR_FAULT_CODE = 1,
   parameter int REG_INPUTS     = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [TAG_W-1:0]   op_tag,
   input  logic               cond_known,
   input  logic               cond_pass,
   input  logic               ptr_known,
   input  logic               ptr_bad,
   input  logic               unit_ready,
   output logic               dec_valid,
   output logic [1:0]         dec_kind,
   output logic [CAUSE_W-1:0] dec_cause,
   output logic [TAG_W-1:0]   dec_tag
);

   localparam int LAT = 1 + REG_INPUTS;

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
      if (CAUSE_W < 1) begin : g_bad_cause_w
         $error("CAUSE_W must be at least 1");
      end
      if (PTR_FAULT_CODE < 1 || PTR_FAULT_CODE >= (1 << CAUSE_W)) begin : g_bad_code
         $error("PTR_FAULT_CODE must be nonzero and fit in CAUSE_W bits");
      end
      if (REG_INPUTS != 0 && REG_INPUTS != 1) begin : g_bad_reg
         $error("REG_INPUTS must be 0 or 1");
      end
   endgenerate

   op_req_t            req_in;
   op_req_t            req_s;
   logic [TAG_W-1:0]   tag_s;
   logic               vd_valid;
   dec_kind_e          vd_kind;
   logic [CAUSE_W-1:0] vd_cause;
   dec_kind_e          out_kind;

   assign req_in = '{op_valid:   op_valid,
                     cond_known: cond_known,
                     cond_pass:  cond_pass,
                     ptr_known:  ptr_known,
                     ptr_bad:    ptr_bad,
                     unit_ready: unit_ready};

   cmia_capture #(
      .TAG_W      (TAG_W),
      .REG_INPUTS (REG_INPUTS)
   ) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .req_d (req_in),
      .tag_d (op_tag),
      .req_q (req_s),
      .tag_q (tag_s)
   );

   cmia_decide #(
      .CAUSE_W        (CAUSE_W),
      .PTR_FAULT_CODE (PTR_FAULT_CODE)
   ) u_decide (
      .req           (req_s),
      .verdict_valid (vd_valid),
      .verdict       (vd_kind),
      .cause         (vd_cause)
   );

   cmia_hold #(
      .TAG_W   (TAG_W),
      .CAUSE_W (CAUSE_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_d (vd_valid),
      .kind_d  (vd_kind),
      .cause_d (vd_cause),
      .tag_d   (tag_s),
      .valid_q (dec_valid),
      .kind_q  (out_kind),
      .cause_q (dec_cause),
      .tag_q   (dec_tag)
   );

   assign dec_kind = out_kind;

endmodule

// File: rtl/cond_mem_issue_arb_chk.sv
`timescale 1ns/1ps
module cond_mem_issue_arb_chk #(
   parameter int TAG_W          = 4,
   parameter int CAUSE_W        = 3,
   parameter int PTR_FAULT_CODE = 1,
   parameter int LAT            = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_valid,
   input logic [TAG_W-1:0]   op_tag,
   input logic               cond_known,
   input logic               cond_pass,
   input logic               ptr_known,
   input logic               ptr_bad,
   input logic               unit_ready,
   input logic               dec_valid,
   input logic [1:0]         dec_kind,
   input logic [CAUSE_W-1:0] dec_cause,
   input logic [TAG_W-1:0]   dec_tag
);

   logic [1:0] since_rst;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= 2'd0;
      else if (since_rst < 2'(LAT))
         since_rst <= since_rst + 2'd1;
   end

   assign warm = (since_rst >= 2'(LAT));

   // R2
   assert_idle_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(op_valid, LAT)) |-> (!dec_valid && dec_kind == 2'b00));

   // R1
   assert_cold_output_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !warm |-> (!dec_valid && dec_kind == 2'b00 && dec_cause == '0));

   // R3
   assert_stall_cond_unknown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(op_valid, LAT) && !$past(cond_known, LAT))
      |-> (dec_valid && dec_kind == 2'b10));

   // R4
   assert_false_cond_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(op_valid, LAT) && $past(cond_known, LAT) && !$past(cond_pass, LAT))
      |-> (dec_valid && dec_kind == 2'b00 && dec_cause == '0));

   // R6
   assert_fault_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(op_valid, LAT) && $past(cond_known, LAT) && $past(cond_pass, LAT)
       && $past(ptr_known, LAT) && $past(ptr_bad, LAT))
      |-> (dec_valid && dec_kind == 2'b11 && dec_cause == CAUSE_W'(PTR_FAULT_CODE)));

   // R8
   assert_issue_only_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && dec_valid && dec_kind == 2'b01)
      |-> ($past(cond_known, LAT) && $past(cond_pass, LAT) && $past(ptr_known, LAT)
           && !$past(ptr_bad, LAT) && $past(unit_ready, LAT)));

   // R9
   assert_tag_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && dec_valid) |-> (dec_tag == $past(op_tag, LAT)));

   // R10
   assert_cause_only_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_kind != 2'b11) |-> (dec_cause == '0));

endmodule

bind cond_mem_issue_arb cond_mem_issue_arb_chk #(
   .TAG_W          (TAG_W),
   .CAUSE_W        (CAUSE_W),
   .PTR_FAULT_CODE (PTR_FAULT_CODE),
   .LAT            (1 + REG_INPUTS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_tag     (op_tag),
   .cond_known (cond_known),
   .cond_pass  (cond_pass),
   .ptr_known  (ptr_known),
   .ptr_bad    (ptr_bad),
   .unit_ready (unit_ready),
   .dec_valid  (dec_valid),
   .dec_kind   (dec_kind),
   .dec_cause  (dec_cause),
   .dec_tag    (dec_tag)
);

// File: tb/cond_mem_issue_arb_test.sv
`timescale 1ns/1ps
module cond_mem_issue_arb_test;

   localparam int TAG_W      = 4;
   localparam int CAUSE_W    = 3;
   localparam int FAULT_CODE = 1;
   localparam int REG_INPUTS = 1;
   localparam int LAT        = 1 + REG_INPUTS;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               op_valid, cond_known, cond_pass, ptr_known, ptr_bad, unit_ready;
   logic [TAG_W-1:0]   op_tag;
   logic               dec_valid;
   logic [1:0]         dec_kind;
   logic [CAUSE_W-1:0] dec_cause;
   logic [TAG_W-1:0]   dec_tag;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   logic [5:0]       hist_v [4];
   logic [TAG_W-1:0] hist_t [4];
   int               sent = 0;

   always #2.5 clk = ~clk;

   cond_mem_issue_arb #(
      .TAG_W          (TAG_W),
      .CAUSE_W        (CAUSE_W),
      .PTR_FAULT_CODE (FAULT_CODE),
      .REG_INPUTS     (REG_INPUTS)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_tag     (op_tag),
      .cond_known (cond_known),
      .cond_pass  (cond_pass),
      .ptr_known  (ptr_known),
      .ptr_bad    (ptr_bad),
      .unit_ready (unit_ready),
      .dec_valid  (dec_valid),
      .dec_kind   (dec_kind),
      .dec_cause  (dec_cause),
      .dec_tag    (dec_tag)
   );

   // vector bits: 0 op_valid, 1 cond_known, 2 cond_pass, 3 ptr_known, 4 ptr_bad, 5 unit_ready
   function automatic logic [1:0] exp_kind(input logic [5:0] v);
      if (!v[0])      return 2'b00;
      else if (!v[1]) return 2'b10;
      else if (!v[2]) return 2'b00;
      else if (!v[3]) return 2'b10;
      else if (v[4])  return 2'b11;
      else if (!v[5]) return 2'b10;
      else            return 2'b01;
   endfunction

   function automatic string req_of(input logic [5:0] v);
      if (!v[0])      return "R2";
      else if (!v[1]) return "R3";
      else if (!v[2]) return "R4";
      else if (!v[3]) return "R5";
      else if (v[4])  return "R6";
      else if (!v[5]) return "R7";
      else            return "R8";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] v, input logic [TAG_W-1:0] t);
      op_valid   = v[0];
      cond_known = v[1];
      cond_pass  = v[2];
      ptr_known  = v[3];
      ptr_bad    = v[4];
      unit_ready = v[5];
      op_tag     = t;
   endtask

   task automatic compare_slot();
      logic [5:0]       v;
      logic [TAG_W-1:0] t;
      logic [1:0]       ek;
      int               ec;
      string            rq;
      v  = hist_v[(sent - LAT) % 4];
      t  = hist_t[(sent - LAT) % 4];
      ek = exp_kind(v);
      ec = (ek == 2'b11) ? FAULT_CODE : 0;
      rq = req_of(v);
      check(dec_valid == v[0], rq, "valid", int'(dec_valid), int'(v[0]));
      check(dec_kind == ek, rq, "kind", int'(dec_kind), int'(ek));
      check(int'(dec_cause) == ec, (ek == 2'b11) ? "R6" : "R10", "cause",
            int'(dec_cause), ec);
      if (v[0])
         check(dec_tag == t, "R9", "tag", int'(dec_tag), int'(t));
   endtask

   task automatic step(input logic [5:0] v, input logic [TAG_W-1:0] t);
      @(negedge clk);
      if (sent >= LAT) compare_slot();
      drive(v, t);
      hist_v[sent % 4] = v;
      hist_t[sent % 4] = t;
      sent++;
   endtask

   initial begin
      rst_n = 1'b0;
      drive(6'h3f, '1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs while reset is held, with busy inputs
      check(dec_valid == 1'b0, "R1", "valid", int'(dec_valid), 0);
      check(dec_kind == 2'b00, "R1", "kind", int'(dec_kind), 0);
      check(dec_cause == '0, "R1", "cause", int'(dec_cause), 0);
      rst_n = 1'b1;
      // R9: first pass in counting order, a new request every cycle
      for (int i = 0; i < 64; i++) step(6'(i), TAG_W'(i));
      // R4 and R6 next to unlike neighbours: second pass in a scrambled order
      for (int i = 0; i < 64; i++) step(6'((i * 37 + 11) % 64), TAG_W'(i + 5));
      for (int i = 0; i < LAT; i++) step(6'h00, '0);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule